// File: doc/BRIEF.md
# Linear Framebuffer Display Control Register File

This block is the host-facing register file of a linear framebuffer display controller. A host reaches it through a single request port that selects one of two windows. The first window holds an array of 16-bit configuration registers: resolution, colour depth, enable, virtual width and panning offsets. These registers are addressed by byte, and the register index is the byte address with its lowest bit dropped. The second window is a small 32-bit extension area. It reports its own length and holds a framebuffer byte-order control.

A few register indices return fixed or derived values instead of stored contents. One is the controller identification code. Another is the size of video memory, counted in 64 KiB units. Accesses past the end of the register array and accesses of the wrong width to the extension window are handled without side effects. The stored values and the byte-order flag are driven out continuously to the mode logic.

Every access runs through a three-state sequencer. In ST_IDLE the block accepts a request (transition ACCEPT). ST_DECODE performs the write or captures the read data (transition EXECUTE). ST_REPLY presents the response for one cycle (transition RETIRE) and then returns to ST_IDLE.

Top module: `fbctl_regs`

## Requirements
- R1: After reset every stored register and the byte-order flag are zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A register-window write to a stored index (1 X resolution, 2 Y resolution, 3 colour depth, 4 enable, 5 spare, 6 virtual width, 7 spare, 8 X offset, 9 Y offset) is read back unchanged. The matching `cfg_*` output shows it in the response cycle.
- R3: A read of register index 0 always returns 0x0000B0C5, even after a write to that index.
- R4: A read of register index 10 returns MEM_BYTES / 65536 (256 by default). A write to that index does not change this.
- R5: With 11 registers, a read at an index of 11 or more returns 0x0000FFFF, and a write at such an index changes no output.
- R6: The register index is the byte address shifted right by one, so the odd address 2k+1 reaches the same register as 2k.
- R7: In the extension window, offset 0 reads as the window length EXT_LEN (8 by default). Offsets other than 0 and 4 read as zero.
- R8: A write to extension offset 4 sets the byte-order flag only for the value 0xBEBEBEBE and clears it only for 0x1E1E1E1E. Any other value leaves it unchanged. A read of offset 4 returns 0xBEBEBEBE when the flag is set and 0x1E1E1E1E otherwise.
- R9: An extension access whose `req_size` is not 4 writes nothing and reads as zero.
- R10: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is then low for two cycles. `rsp_valid` is high for exactly the second of those cycles, and `req_ready` returns the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer is in ST_IDLE and takes a request |
| req_win | input | 1 | 0 = register window, 1 = extension window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the selected window |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data (low 16 bits for the register window) |
| rsp_valid | output | 1 | Response cycle |
| rsp_data | output | 32 | Read data, valid with rsp_valid |
| cfg_xres | output | 16 | Stored X resolution |
| cfg_yres | output | 16 | Stored Y resolution |
| cfg_bpp | output | 16 | Stored colour depth |
| cfg_enable | output | 16 | Stored enable word |
| cfg_vwidth | output | 16 | Stored virtual width |
| cfg_xoff | output | 16 | Stored X offset |
| cfg_yoff | output | 16 | Stored Y offset |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |

## Verification
The embedded assertions check these rules on every cycle:
- the sequencer timing of R10;
- the fixed identification value and the all-ones out-of-range read of R3 and R5;
- the rule that out-of-range writes, unrecognised byte-order codes and wrongly sized extension writes leave state untouched (R5, R8, R9).

Only the bench scenarios can show the rest:
- read-back of stored values through the `cfg_*` outputs;
- aliasing of odd addresses onto their even neighbour;
- the derived memory-size value surviving a write;
- the extension window's length and zero offsets;
- the set-then-clear history of the byte-order flag.

// File: rtl/fbctl_pkg.sv
`timescale 1ns/1ps
package fbctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_REPLY  = 2'd2
    } seq_state_t;

    localparam int IDX_ID     = 0;
    localparam int IDX_XRES   = 1;
    localparam int IDX_YRES   = 2;
    localparam int IDX_BPP    = 3;
    localparam int IDX_ENABLE = 4;
    localparam int IDX_VWIDTH = 6;
    localparam int IDX_XOFF   = 8;
    localparam int IDX_YOFF   = 9;
    localparam int IDX_MEMSZ  = 10;

    localparam logic [15:0] CTRL_ID_VALUE = 16'hB0C5;
    localparam logic [31:0] ORDER_BIG     = 32'hBEBEBEBE;
    localparam logic [31:0] ORDER_LITTLE  = 32'h1E1E1E1E;

    localparam int EXT_OFS_LEN   = 0;
    localparam int EXT_OFS_ORDER = 4;
    localparam int EXT_WORD_SIZE = 4;
endpackage

// File: rtl/fbctl_seq.sv
`timescale 1ns/1ps
module fbctl_seq
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_win,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              bank_rd,
    output logic              bank_wr,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [2:0]        acc_size,
    output logic [31:0]       acc_wdata,
    output logic              rsp_valid,
    output logic              rsp_sel_ext
);
    seq_state_t state_q, state_d;
    logic       win_q, write_q;

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            win_q     <= 1'b0;
            write_q   <= 1'b0;
            acc_addr  <= '0;
            acc_size  <= '0;
            acc_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                win_q     <= req_win;
                write_q   <= req_write;
                acc_addr  <= req_addr;
                acc_size  <= req_size;
                acc_wdata <= req_wdata;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DECODE; // ACCEPT
            ST_DECODE: state_d = ST_REPLY;                 // EXECUTE
            ST_REPLY:  state_d = ST_IDLE;                  // RETIRE
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready   = 1'b0;
        bank_rd     = 1'b0;
        bank_wr     = 1'b0;
        ext_rd      = 1'b0;
        ext_wr      = 1'b0;
        rsp_valid   = 1'b0;
        rsp_sel_ext = win_q;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_DECODE: begin
                bank_rd = !win_q && !write_q;
                bank_wr = !win_q &&  write_q;
                ext_rd  =  win_q && !write_q;
                ext_wr  =  win_q &&  write_q;
            end
            ST_REPLY: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // R10
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));
    // R10
    reply_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd || bank_wr || ext_rd || ext_wr) |=> (rsp_valid && !req_ready));
    // R10
    retire_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));
endmodule

// File: rtl/fbctl_bank.sv
`timescale 1ns/1ps
module fbctl_bank
    import fbctl_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int NUM_REGS  = 11,
    parameter int MEM_BYTES = 16 * 1024 * 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata,
    output logic [15:0]      cfg_xres,
    output logic [15:0]      cfg_yres,
    output logic [15:0]      cfg_bpp,
    output logic [15:0]      cfg_enable,
    output logic [15:0]      cfg_vwidth,
    output logic [15:0]      cfg_xoff,
    output logic [15:0]      cfg_yoff
);
    localparam logic [15:0]      MEM_UNITS = 16'(MEM_BYTES / 65536);
    localparam logic [IDX_W-1:0] NUM_IDX   = IDX_W'(NUM_REGS);
    localparam logic [IDX_W-1:0] ID_IDX    = IDX_W'(IDX_ID);
    localparam logic [IDX_W-1:0] MEM_IDX   = IDX_W'(IDX_MEMSZ);

    logic [15:0] regs_q [NUM_REGS];
    logic [15:0] stored_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (idx == IDX_W'(i)) regs_q[i] <= wdata;
        end
    end

    always_comb begin
        stored_rd = 16'hFFFF;
        for (int i = 0; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) stored_rd = regs_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            if (idx == ID_IDX)        rdata <= CTRL_ID_VALUE;
            else if (idx == MEM_IDX)  rdata <= MEM_UNITS;
            else if (idx >= NUM_IDX)  rdata <= 16'hFFFF;
            else                      rdata <= stored_rd;
        end
    end

    assign cfg_xres   = regs_q[IDX_XRES];
    assign cfg_yres   = regs_q[IDX_YRES];
    assign cfg_bpp    = regs_q[IDX_BPP];
    assign cfg_enable = regs_q[IDX_ENABLE];
    assign cfg_vwidth = regs_q[IDX_VWIDTH];
    assign cfg_xoff   = regs_q[IDX_XOFF];
    assign cfg_yoff   = regs_q[IDX_YOFF];

    // R3
    id_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == ID_IDX) |=> (rdata == CTRL_ID_VALUE));
    // R5
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx >= NUM_IDX) |=> (rdata == 16'hFFFF));
    // R5
    oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx >= NUM_IDX) |=>
        $stable({cfg_xres, cfg_yres, cfg_bpp, cfg_enable, cfg_vwidth, cfg_xoff, cfg_yoff}));
endmodule

// File: rtl/fbctl_ext.sv
`timescale 1ns/1ps
module fbctl_ext
    import fbctl_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int EXT_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              big_endian
);
    localparam logic [ADDR_W-1:0] OFS_LEN   = ADDR_W'(EXT_OFS_LEN);
    localparam logic [ADDR_W-1:0] OFS_ORDER = ADDR_W'(EXT_OFS_ORDER);

    logic size_ok;
    assign size_ok = (size == 3'(EXT_WORD_SIZE));

    always_ff @(posedge clk) begin
        if (!rst_n) big_endian <= 1'b0;
        else if (wr_en && size_ok && addr == OFS_ORDER) begin
            if (wdata == ORDER_BIG)         big_endian <= 1'b1;
            else if (wdata == ORDER_LITTLE) big_endian <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            if (!size_ok)                rdata <= '0;
            else if (addr == OFS_LEN)    rdata <= 32'(EXT_LEN);
            else if (addr == OFS_ORDER)  rdata <= big_endian ? ORDER_BIG : ORDER_LITTLE;
            else                         rdata <= '0;
        end
    end

    // R8
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_ORDER && wdata != ORDER_BIG && wdata != ORDER_LITTLE)
        |=> $stable(big_endian));
    // R9
    width_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !size_ok) |=> $stable(big_endian));
    // R9
    width_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !size_ok) |=> (rdata == '0));
endmodule

// File: rtl/fbctl_regs.sv
`timescale 1ns/1ps
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_REGS  = 11,
    parameter int MEM_BYTES = 16 * 1024 * 1024,
    parameter int EXT_LEN   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_win,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic [15:0]       cfg_xres,
    output logic [15:0]       cfg_yres,
    output logic [15:0]       cfg_bpp,
    output logic [15:0]       cfg_enable,
    output logic [15:0]       cfg_vwidth,
    output logic [15:0]       cfg_xoff,
    output logic [15:0]       cfg_yoff,
    output logic              fb_big_endian
);
    localparam int IDX_W = ADDR_W - 1;

    logic              bank_rd, bank_wr, ext_rd, ext_wr, sel_ext;
    logic [ADDR_W-1:0] acc_addr;
    logic [2:0]        acc_size;
    logic [31:0]       acc_wdata, ext_rdata;
    logic [15:0]       bank_rdata;

    fbctl_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_win(req_win),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata),
        .bank_rd(bank_rd), .bank_wr(bank_wr), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_sel_ext(sel_ext)
    );

    fbctl_bank #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .MEM_BYTES(MEM_BYTES)) u_bank (
        .clk(clk), .rst_n(rst_n), .rd_en(bank_rd), .wr_en(bank_wr),
        .idx(acc_addr[ADDR_W-1:1]), .wdata(acc_wdata[15:0]), .rdata(bank_rdata),
        .cfg_xres(cfg_xres), .cfg_yres(cfg_yres), .cfg_bpp(cfg_bpp),
        .cfg_enable(cfg_enable), .cfg_vwidth(cfg_vwidth),
        .cfg_xoff(cfg_xoff), .cfg_yoff(cfg_yoff)
    );

    fbctl_ext #(.ADDR_W(ADDR_W), .EXT_LEN(EXT_LEN)) u_ext (
        .clk(clk), .rst_n(rst_n), .rd_en(ext_rd), .wr_en(ext_wr),
        .addr(acc_addr), .size(acc_size), .wdata(acc_wdata),
        .rdata(ext_rdata), .big_endian(fb_big_endian)
    );

    always_comb begin
        rsp_data = '0;
        if (rsp_valid) rsp_data = sel_ext ? ext_rdata : {16'h0000, bank_rdata};
    end
endmodule

// File: tb/sim_fbctl_regs.sv
`timescale 1ns/1ps
module sim_fbctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_win = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [2:0]  req_size = 3'd2;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, fb_big_endian;
    logic [31:0] rsp_data;
    logic [15:0] cfg_xres, cfg_yres, cfg_bpp, cfg_enable, cfg_vwidth, cfg_xoff, cfg_yoff;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    fbctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_win(req_win), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .cfg_xres(cfg_xres), .cfg_yres(cfg_yres),
        .cfg_bpp(cfg_bpp), .cfg_enable(cfg_enable), .cfg_vwidth(cfg_vwidth),
        .cfg_xoff(cfg_xoff), .cfg_yoff(cfg_yoff), .fb_big_endian(fb_big_endian)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One full access; returns the data seen in the response cycle
    task automatic access(input logic win, input logic wr, input logic [5:0] addr,
                          input logic [2:0] size, input logic [31:0] wd,
                          output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_win = win; req_write = wr;
        req_addr = addr; req_size = size; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rd = rsp_data;
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [15:0] d);
        logic [31:0] unused_rd;
        access(1'b0, 1'b1, a, 3'd2, {16'h0, d}, unused_rd);
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
        access(1'b0, 1'b0, a, 3'd2, 32'h0, d);
    endtask

    task automatic t_reset;
        chk("R1 xres", {16'h0, cfg_xres}, 0);
        chk("R1 vwidth", {16'h0, cfg_vwidth}, 0);
        chk("R1 order", {31'h0, fb_big_endian}, 0);
        chk("R1 ready", {31'h0, req_ready}, 1);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        req_valid = 1'b1; req_win = 1'b0; req_write = 1'b0; req_addr = 6'd2; req_size = 3'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy1 ready", {31'h0, req_ready}, 0);
        chk("R10 busy1 rsp", {31'h0, rsp_valid}, 0);
        @(negedge clk);
        chk("R10 reply rsp", {31'h0, rsp_valid}, 1);
        chk("R10 reply ready", {31'h0, req_ready}, 0);
        @(negedge clk);
        chk("R10 retire rsp", {31'h0, rsp_valid}, 0);
        chk("R10 retire ready", {31'h0, req_ready}, 1);
    endtask

    task automatic t_stored;
        logic [31:0] d;
        reg_wr(6'd2, 16'd640);  reg_wr(6'd4, 16'd480);  reg_wr(6'd6, 16'd32);
        reg_wr(6'd8, 16'h0001); reg_wr(6'd12, 16'd800); reg_wr(6'd16, 16'd7);
        reg_wr(6'd18, 16'd9);   reg_wr(6'd10, 16'hA5A5); reg_wr(6'd14, 16'h5A5A);
        chk("R2 cfg_xres", {16'h0, cfg_xres}, 640);
        chk("R2 cfg_yres", {16'h0, cfg_yres}, 480);
        chk("R2 cfg_bpp", {16'h0, cfg_bpp}, 32);
        chk("R2 cfg_enable", {16'h0, cfg_enable}, 1);
        chk("R2 cfg_vwidth", {16'h0, cfg_vwidth}, 800);
        chk("R2 cfg_xoff", {16'h0, cfg_xoff}, 7);
        chk("R2 cfg_yoff", {16'h0, cfg_yoff}, 9);
        reg_rd(6'd2, d);  chk("R2 read xres", d, 640);
        reg_rd(6'd10, d); chk("R2 read spare5", d, 32'hA5A5);
        reg_rd(6'd14, d); chk("R2 read spare7", d, 32'h5A5A);
        reg_rd(6'd18, d); chk("R2 read yoff", d, 9);
    endtask

    task automatic t_synth;
        logic [31:0] d;
        reg_rd(6'd0, d);  chk("R3 id", d, 32'hB0C5);
        reg_wr(6'd0, 16'h1234);
        reg_rd(6'd0, d);  chk("R3 id after write", d, 32'hB0C5);
        reg_rd(6'd20, d); chk("R4 memsize", d, 256);
        reg_wr(6'd20, 16'h0003);
        reg_rd(6'd20, d); chk("R4 memsize after write", d, 256);
    endtask

    task automatic t_out_of_range;
        logic [31:0] d;
        reg_rd(6'd22, d); chk("R5 read idx11", d, 32'hFFFF);
        reg_rd(6'd62, d); chk("R5 read idx31", d, 32'hFFFF);
        reg_wr(6'd22, 16'hDEAD);
        reg_wr(6'd63, 16'hBEEF);
        chk("R5 xres kept", {16'h0, cfg_xres}, 640);
        chk("R5 yoff kept", {16'h0, cfg_yoff}, 9);
        chk("R5 enable kept", {16'h0, cfg_enable}, 1);
        reg_rd(6'd22, d); chk("R5 idx11 still ones", d, 32'hFFFF);
    endtask

    task automatic t_odd;
        logic [31:0] d;
        reg_rd(6'd5, d); chk("R6 odd read yres", d, 480);
        reg_wr(6'd17, 16'd21);
        chk("R6 odd write xoff", {16'h0, cfg_xoff}, 21);
        reg_rd(6'd16, d); chk("R6 even read back", d, 21);
    endtask

    task automatic t_ext;
        logic [31:0] d;
        access(1'b1, 1'b0, 6'd0, 3'd4, 0, d);  chk("R7 ext length", d, 8);
        access(1'b1, 1'b0, 6'd8, 3'd4, 0, d);  chk("R7 ext unimpl 8", d, 0);
        access(1'b1, 1'b0, 6'd12, 3'd4, 0, d); chk("R7 ext unimpl 12", d, 0);
        access(1'b1, 1'b0, 6'd4, 3'd4, 0, d);  chk("R8 order initial", d, 32'h1E1E1E1E);
        access(1'b1, 1'b1, 6'd4, 3'd4, 32'hBEBEBEBE, d);
        chk("R8 set big", {31'h0, fb_big_endian}, 1);
        access(1'b1, 1'b0, 6'd4, 3'd4, 0, d);  chk("R8 read big", d, 32'hBEBEBEBE);
        access(1'b1, 1'b1, 6'd4, 3'd4, 32'h00000001, d);
        chk("R8 other value keeps set", {31'h0, fb_big_endian}, 1);
        access(1'b1, 1'b1, 6'd4, 3'd2, 32'h1E1E1E1E, d);
        chk("R9 narrow write ignored", {31'h0, fb_big_endian}, 1);
        access(1'b1, 1'b0, 6'd0, 3'd2, 0, d);  chk("R9 narrow read zero", d, 0);
        access(1'b1, 1'b0, 6'd4, 3'd1, 0, d);  chk("R9 byte read zero", d, 0);
        access(1'b1, 1'b1, 6'd4, 3'd4, 32'h1E1E1E1E, d);
        chk("R8 clear little", {31'h0, fb_big_endian}, 0);
        access(1'b1, 1'b1, 6'd4, 3'd4, 32'hBEBEBEBF, d);
        chk("R8 near code keeps clear", {31'h0, fb_big_endian}, 0);
        access(1'b1, 1'b0, 6'd4, 3'd4, 0, d);  chk("R8 read little", d, 32'h1E1E1E1E);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_stored();
        t_synth();
        t_out_of_range();
        t_odd();
        t_ext();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule